// File: doc/BRIEF.md
# Three-Stage In-Order Integer Core

This block is a small in-order integer processor. Its pipeline has three stages. Fetch reads one instruction word per cycle from a 128-entry instruction store. The read stage decodes the word and collects its operands from a 128-entry register file. The execute stage computes the result, writes it back, and resolves branches. The instruction set has five operations: two register-register arithmetic operations, two register-immediate arithmetic operations, and one conditional branch taken on inequality. There is no branch prediction. After fetch issues a branch, it holds until execute returns the next program counter. An instruction that reads a register written by the instruction just ahead of it takes the value straight from the execute stage.

The program is loaded through a write port into the instruction store, normally while reset is held. The processor starts at address 0 when reset is released. Register contents can be observed at any time on a combinational debug read port.

Top module: `tpc_core`

## Requirements
- R1: Asserting reset (rst_n low, asynchronous) sets the program counter to 0, clears every pipeline valid bit, releases any branch hold and sets all 128 registers to 0. The debug port then reads 0 for every register.
- R2: An instruction word is decoded as op[31:29], rd[28:22], rs[21:15], rt[14:8] and a signed 8-bit immediate in [7:0]. The op codes are ADD=0, SUB=1, ADDI=2, SUBI=3 and BNE=4.
- R3: ADD writes rs+rt to rd and SUB writes rs-rt to rd, both in 32-bit modulo arithmetic. The new value is visible on the debug port three cycles after the instruction is fetched.
- R4: ADDI writes rs plus the sign-extended immediate to rd. SUBI writes rs minus the sign-extended immediate to rd.
- R5: When no branch is outstanding, fetch issues one instruction per cycle and the program counter advances by one each cycle, wrapping from 127 to 0.
- R6: After a BNE is fetched, no further instruction is issued until that BNE resolves in execute. The next fetch therefore comes three cycles after the BNE's fetch.
- R7: A BNE whose rs and rt values differ goes to its own address plus the sign-extended immediate, modulo 128. A negative offset branches backwards. When the values are equal, the next address is the BNE's address plus one.
- R8: An instruction that reads a register written by the instruction immediately before it sees the new value. This holds for arithmetic operands and for BNE compare operands.
- R9: Op codes 5, 6 and 7 write no register and cause no hold.
- R10: Register 0 is an ordinary register that can be written and read like any other.
- R11: dbg_rdata combinationally returns the register selected by dbg_raddr.
- R12: A cycle with imem_we high stores imem_wdata at imem_waddr in the instruction store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | 7 | Instruction store write address |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_raddr | input | 7 | Register selected for debug read |
| dbg_rdata | output | 32 | Contents of the selected register |

## Verification
The assertions check the control rules on every cycle. While a branch hold is active, no instruction enters the read stage. The program counter steps by exactly one after each non-branch issue. At most one branch is in flight at a time. A branch in execute always finds fetch holding, and the redirect releases the hold and loads the target. Reserved op codes in execute never raise the write enable.

Only the bench scenarios can show the arithmetic results, sign extension, forwarding, backward and wrapping branch targets, the write to register 0, and the exact cycle in which each write appears. The bench shows these by comparing the debug port every cycle against a program-level reference model that has its own timing.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

    localparam int INSN_W   = 32;
    localparam int REG_AW   = 7;
    localparam int IMM_W    = 8;
    localparam int OPC_W    = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_ADDI = 3'd2,
        OP_SUBI = 3'd3,
        OP_BNE  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } opc_e;

    typedef struct packed {
        opc_e              op;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [IMM_W-1:0]  imm;
    } insn_t;

    function automatic logic op_writes(input opc_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_ADDI) || (op == OP_SUBI);
    endfunction

endpackage

// File: rtl/tpc_imem.sv
module tpc_imem #(
    parameter int DW = 32,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/tpc_regfile.sv
module tpc_regfile #(
    parameter int DW = 32,
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] ra_a,
    output logic [DW-1:0] rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [DW-1:0] rd_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [DW-1:0] rd_dbg
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] rf_q [DEPTH];
    logic [DW-1:0] rf_d [DEPTH];

    always_comb begin
        rf_d = rf_q;
        if (we) rf_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) rf_q[i] <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_a   = rf_q[ra_a];
    assign rd_b   = rf_q[ra_b];
    assign rd_dbg = rf_q[ra_dbg];
endmodule

// File: rtl/tpc_exec.sv
module tpc_exec
    import tpc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 7
) (
    input  logic             vld,
    input  opc_e             op,
    input  logic [DW-1:0]    opa,
    input  logic [DW-1:0]    opb,
    input  logic [IMM_W-1:0] imm,
    input  logic [AW-1:0]    pc,
    output logic             wr_en,
    output logic [DW-1:0]    wr_val,
    output logic             redir,
    output logic [AW-1:0]    redir_pc
);
    logic [DW-1:0] imm_x;
    logic          differ;

    always_comb begin
        imm_x    = {{(DW-IMM_W){imm[IMM_W-1]}}, imm};
        differ   = (opa != opb);
        wr_en    = vld && op_writes(op);
        redir    = vld && (op == OP_BNE);
        redir_pc = pc + AW'(1);
        wr_val   = '0;
        unique case (op)
            OP_ADD:  wr_val = opa + opb;
            OP_SUB:  wr_val = opa - opb;
            OP_ADDI: wr_val = opa + imm_x;
            OP_SUBI: wr_val = opa - imm_x;
            OP_BNE:  if (differ) redir_pc = pc + imm_x[AW-1:0];
            default: wr_val = '0;
        endcase
    end
endmodule

// File: rtl/tpc_core.sv
module tpc_core
    import tpc_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          imem_we,
    input  logic [AW-1:0] imem_waddr,
    input  logic [DW-1:0] imem_wdata,
    input  logic [AW-1:0] dbg_raddr,
    output logic [DW-1:0] dbg_rdata
);
    typedef struct packed {
        logic          vld;
        insn_t         ins;
        logic [AW-1:0] pc;
    } rd_stage_t;

    typedef struct packed {
        logic             vld;
        opc_e             op;
        logic [AW-1:0]    rd;
        logic [DW-1:0]    opa;
        logic [DW-1:0]    opb;
        logic [IMM_W-1:0] imm;
        logic [AW-1:0]    pc;
    } ex_stage_t;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          hold;
        rd_stage_t     rs;
        ex_stage_t     ex;
    } core_st_t;

    core_st_t st_q, st_d;

    logic [DW-1:0] imem_rdata;
    insn_t         fetch_ins;
    logic          fetch_is_br;
    logic [DW-1:0] rf_a, rf_b;
    logic          wr_en, redir;
    logic [DW-1:0] wr_val;
    logic [AW-1:0] redir_pc;

    // observation nets for the bound checker
    logic          pc_hold;
    logic [AW-1:0] pc_cur;
    logic          rs_vld, rs_is_br, ex_vld, ex_is_br;
    logic [OPC_W-1:0] ex_opc;

    tpc_imem #(.DW(DW), .AW(AW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (imem_waddr),
        .wdata (imem_wdata),
        .raddr (st_q.pc),
        .rdata (imem_rdata)
    );

    tpc_regfile #(.DW(DW), .AW(AW)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_en),
        .waddr  (st_q.ex.rd),
        .wdata  (wr_val),
        .ra_a   (st_q.rs.ins.rs),
        .rd_a   (rf_a),
        .ra_b   (st_q.rs.ins.rt),
        .rd_b   (rf_b),
        .ra_dbg (dbg_raddr),
        .rd_dbg (dbg_rdata)
    );

    tpc_exec #(.DW(DW), .AW(AW)) u_exec (
        .vld      (st_q.ex.vld),
        .op       (st_q.ex.op),
        .opa      (st_q.ex.opa),
        .opb      (st_q.ex.opb),
        .imm      (st_q.ex.imm),
        .pc       (st_q.ex.pc),
        .wr_en    (wr_en),
        .wr_val   (wr_val),
        .redir    (redir),
        .redir_pc (redir_pc)
    );

    always_comb begin
        st_d        = st_q;
        fetch_ins   = insn_t'(imem_rdata);
        fetch_is_br = (fetch_ins.op == OP_BNE);

        // fetch: one word per cycle unless a branch is outstanding
        st_d.rs.vld = !st_q.hold;
        st_d.rs.ins = fetch_ins;
        st_d.rs.pc  = st_q.pc;
        if (!st_q.hold) begin
            if (fetch_is_br) st_d.hold = 1'b1;
            else             st_d.pc   = st_q.pc + AW'(1);
        end
        if (redir) begin
            st_d.hold = 1'b0;
            st_d.pc   = redir_pc;
        end

        // read stage with bypass from the instruction now in execute
        st_d.ex.vld = st_q.rs.vld;
        st_d.ex.op  = st_q.rs.ins.op;
        st_d.ex.rd  = st_q.rs.ins.rd;
        st_d.ex.imm = st_q.rs.ins.imm;
        st_d.ex.pc  = st_q.rs.pc;
        st_d.ex.opa = (wr_en && st_q.ex.rd == st_q.rs.ins.rs) ? wr_val : rf_a;
        st_d.ex.opb = (wr_en && st_q.ex.rd == st_q.rs.ins.rt) ? wr_val : rf_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc     <= '0;
            st_q.hold   <= 1'b0;
            st_q.rs     <= '0;
            st_q.ex     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_hold  = st_q.hold;
    assign pc_cur   = st_q.pc;
    assign rs_vld   = st_q.rs.vld;
    assign rs_is_br = (st_q.rs.ins.op == OP_BNE);
    assign ex_vld   = st_q.ex.vld;
    assign ex_is_br = (st_q.ex.op == OP_BNE);
    assign ex_opc   = st_q.ex.op;
endmodule

// File: rtl/tpc_core_chk.sv
module tpc_core_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pc_hold,
    input logic [AW-1:0] pc_cur,
    input logic          fetch_is_br,
    input logic          rs_vld,
    input logic          rs_is_br,
    input logic          ex_vld,
    input logic          ex_is_br,
    input logic [2:0]    ex_opc,
    input logic          wr_en,
    input logic [AW-1:0] redir_pc
);
    // R6
    hold_blocks_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> !rs_vld);

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_hold && !fetch_is_br) |=> (pc_cur == $past(pc_cur) + AW'(1)));

    // R6
    one_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rs_vld && rs_is_br, ex_vld && ex_is_br}) <= 1);

    // R6
    branch_sees_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld && ex_is_br) |-> pc_hold);

    // R7
    redirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld && ex_is_br) |=> (!pc_hold && pc_cur == $past(redir_pc)));

    // R9
    reserved_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_vld && ex_opc >= 3'd5) |-> !wr_en);
endmodule

bind tpc_core tpc_core_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_hold     (pc_hold),
    .pc_cur      (pc_cur),
    .fetch_is_br (fetch_is_br),
    .rs_vld      (rs_vld),
    .rs_is_br    (rs_is_br),
    .ex_vld      (ex_vld),
    .ex_is_br    (ex_is_br),
    .ex_opc      (ex_opc),
    .wr_en       (wr_en),
    .redir_pc    (redir_pc)
);

// File: tb/tb_tpc_core.sv
module tb_tpc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [6:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [6:0]  dbg_raddr = '0;
    logic [31:0] dbg_rdata;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    logic [31:0] im   [128];
    logic [31:0] arch [128];
    logic [31:0] vis  [128];
    int          pq_t [$];
    int          pq_r [$];
    logic [31:0] pq_v [$];

    always #5 clk = ~clk;

    tpc_core dut (
        .clk(clk), .rst_n(rst_n), .imem_we(imem_we), .imem_waddr(imem_waddr),
        .imem_wdata(imem_wdata), .dbg_raddr(dbg_raddr), .dbg_rdata(dbg_rdata)
    );

    function automatic logic [31:0] enc(input int op, input int rd, input int rs,
                                        input int rt, input int imm);
        return {op[2:0], rd[6:0], rs[6:0], rt[6:0], imm[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %0d (0x%08h) expected %0d (0x%08h)", req, $signed(got), got,
                     $signed(exp), exp);
        end
    endtask

    // R12: program the store through the write port while reset is held
    task automatic load_all();
        for (int a = 0; a < 128; a++) begin
            @(negedge clk);
            imem_we = 1'b1; imem_waddr = 7'(a); imem_wdata = im[a];
        end
        @(negedge clk);
        imem_we = 1'b0;
    endtask

    // behavioural model: program order, write visible 3 periods after fetch,
    // next fetch 1 period later or 3 after a branch
    task automatic run(input string req, input int periods, input int watch[8]);
        int          nf = 0;
        logic [6:0]  mpc = '0;
        for (int i = 0; i < 128; i++) begin arch[i] = '0; vis[i] = '0; end
        pq_t.delete(); pq_r.delete(); pq_v.delete();
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < periods; k++) begin
            dbg_raddr = 7'(watch[k % 8]);
            #1;
            check(req, dbg_rdata, vis[watch[k % 8]]);
            if (k == nf) begin
                logic [31:0]       w = im[mpc];
                int                op = int'(w[31:29]);
                int                rd = int'(w[28:22]);
                int                rs = int'(w[21:15]);
                int                rt = int'(w[14:8]);
                logic signed [31:0] sx = {{24{w[7]}}, w[7:0]};
                logic [31:0]       val = '0;
                bit                wr = 1;
                nf = k + 1;
                case (op)
                    0: val = arch[rs] + arch[rt];
                    1: val = arch[rs] - arch[rt];
                    2: val = arch[rs] + sx;
                    3: val = arch[rs] - sx;
                    default: wr = 0;
                endcase
                if (op == 4) begin
                    nf = k + 3;
                    if (arch[rs] != arch[rt]) mpc = mpc + sx[6:0];
                    else                      mpc = mpc + 7'd1;
                end else begin
                    mpc = mpc + 7'd1;
                end
                if (wr) begin
                    arch[rd] = val;
                    pq_t.push_back(k + 3); pq_r.push_back(rd); pq_v.push_back(val);
                end
            end
            while (pq_t.size() > 0 && pq_t[0] == k + 1) begin
                vis[pq_r[0]] = pq_v[0];
                void'(pq_t.pop_front()); void'(pq_r.pop_front()); void'(pq_v.pop_front());
            end
            @(negedge clk);
        end
        // full sweep through the debug port (R11)
        for (int r = 0; r < 128; r++) begin
            dbg_raddr = 7'(r);
            #1;
            check({req, "/R11"}, dbg_rdata, vis[r]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        int w1[8] = '{1, 3, 2, 4, 5, 6, 0, 12};
        int w2[8] = '{10, 11, 12, 0, 1, 3, 10, 11};
        int w3[8] = '{1, 2, 3, 9, 1, 2, 3, 9};

        // program A: arithmetic, forwarding, reserved ops, r0 write, loops
        for (int a = 0; a < 128; a++) im[a] = enc(7, 5, 0, 0, 0);
        im[0]  = enc(2, 2, 100, 0, 4);      // R4
        im[1]  = enc(2, 3, 100, 0, 5);
        im[2]  = enc(0, 1, 2, 3, 0);        // R8: r3 bypassed -> 9
        im[3]  = enc(0, 3, 1, 1, 0);        // R8: r1 bypassed -> 18
        im[4]  = enc(1, 4, 2, 3, 0);        // R3: -14
        im[5]  = enc(3, 5, 4, 0, 8'hFA);    // R4: -14 - (-6) = -8
        im[6]  = enc(2, 6, 5, 0, 8'h80);    // R4: -8 + (-128)
        im[7]  = enc(5, 2, 1, 1, 0);        // R9
        im[8]  = enc(6, 3, 1, 1, 0);        // R9
        im[9]  = enc(7, 4, 1, 1, 0);        // R9
        im[10] = enc(2, 0, 100, 0, 7);      // R10
        im[11] = enc(2, 10, 100, 0, 3);
        im[12] = enc(2, 11, 11, 0, 2);      // loop body
        im[13] = enc(3, 10, 10, 0, 1);
        im[14] = enc(4, 0, 10, 100, 8'hFE); // R7 backward, R8 on compare
        im[15] = enc(4, 0, 10, 0, 1);       // R7 taken forward
        im[16] = enc(4, 0, 2, 2, 5);        // R7 not taken
        im[17] = enc(0, 12, 11, 0, 0);      // 6 + 7 = 13
        im[18] = enc(4, 0, 0, 100, 0);      // self loop
        rst_n = 1'b0;
        load_all();
        // R1: registers read zero under reset
        for (int r = 0; r < 4; r++) begin
            dbg_raddr = 7'(r); #1;
            check("R1", dbg_rdata, 32'd0);
        end
        run("R2/R3/R4/R6/R7/R8/R9/R10", 90, w1);
        run_checks_a();

        // R1: asynchronous reset clears values that were written
        @(negedge clk);
        rst_n = 1'b0;
        dbg_raddr = 7'd3; #1;
        check("R1", dbg_rdata, 32'd0);
        dbg_raddr = 7'd12; #1;
        check("R1", dbg_rdata, 32'd0);

        // program B: same store content, second run from a clean reset
        run("R1/R5/R6", 40, w2);

        // program C: PC wrap and a branch target that wraps below 0
        @(negedge clk);
        rst_n = 1'b0;
        for (int a = 0; a < 128; a++) im[a] = enc(6, 7, 0, 0, 0);
        im[0]   = enc(2, 9, 9, 0, 1);
        im[1]   = enc(4, 0, 9, 8, 8'hFC);   // R7: 1-4 wraps to 125
        im[125] = enc(2, 1, 1, 0, 1);
        im[126] = enc(2, 2, 1, 0, 0);       // R8
        im[127] = enc(1, 3, 2, 9, 0);       // R5: 127 then 0
        load_all();
        run("R5/R7/R8/R12", 70, w3);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    // fixed results of program A taken from the requirements
    task automatic run_checks_a();
        int exp_v [8] = '{9, 18, 4, -14, -8, -136, 7, 13};
        int regs  [8] = '{1, 3, 2, 4, 5, 6, 0, 12};
        for (int i = 0; i < 8; i++) begin
            dbg_raddr = 7'(regs[i]); #1;
            check("R3/R4/R8/R9/R10 final", dbg_rdata, 32'(exp_v[i]));
        end
        dbg_raddr = 7'd11; #1;
        check("R7 loop count", dbg_rdata, 32'd6);
    endtask
endmodule